// File: doc/BRIEF.md
# Raw NAND Flash Bus Controller

This block connects a simple memory-mapped processor bus to one 8-bit raw NAND flash device. Software drives the command-latch, address-latch, chip-select and write-enable-gate pins by writing bits in a control register. It moves each byte with one access to a data port. Every data-port access launches a single strobe: a write-enable low pulse when writing and a read-enable low pulse when reading. The width of that pulse and the hold interval after it come from a timing register and are counted in bus clocks.

The control register also holds a two-bit ECC mode field and a bus-separation flag. Both are passed out on ports to neighbouring logic. A status register shows the device busy line. A soft-reset register returns the control state to its defaults over a fixed number of clocks. While that reset runs, the reset bit reads 1.

A strobe engine carries out each data access. It has three named states: `ST_IDLE` (no strobe), `ST_STROBE` (strobe pin low) and `ST_HOLD` (pins released, write data still driven). The transitions are:
- *launch*: `ST_IDLE`→`ST_STROBE` on an accepted data access.
- *strobe end*: `ST_STROBE`→`ST_HOLD` when the strobe count reaches zero and the hold time is non-zero.
- *strobe end, no hold*: `ST_STROBE`→`ST_IDLE` when the strobe count reaches zero and the hold time is zero.
- *hold end*: `ST_HOLD`→`ST_IDLE` when the hold count reaches zero.
- *abort*: any state→`ST_IDLE` during a soft reset.

A bus access is complete in a cycle where `bus_sel` and `bus_ready` are both high.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, `nf_ce_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_we_n`=1, `nf_re_n`=1, `nf_dq_oe`=0, `nf_wp_n`=0 and `ecc_mode`=00. The control register (address 0) reads 0x00 and the timing register (address 2) reads 0xFF.
- R2: Control bit 0 drives `nf_cle` and control bit 1 drives `nf_ale` directly. Each pin takes the new value in the cycle after the write is accepted.
- R3: Control bit 2 is the chip-select bit. Writing 1 drives `nf_ce_n` low and writing 0 drives it high.
- R4: Control bit 3 is the program-enable bit. When it is 1, `nf_wp_n` is high (writes allowed). When it is 0, `nf_wp_n` is low.
- R5: Control bits [5:4] are the ECC mode (00 off, 01 reset, 10 accumulate, 11 read-out) and appear on `ecc_mode`. Bit 6 is the bus-separation flag and appears on `bus_sep`. Bit 7 is reserved: it reads 0 and has no effect on any pin.
- R6: Timing register (address 2) bits [3:0] hold PW and bits [7:4] hold HOLD. Each strobe lasts PW+1 clocks and is followed by HOLD clocks of hold interval.
- R7: A write to the data port (address 1) is accepted at once when the engine is idle. `nf_we_n` is then low for PW+1 cycles, starting the cycle after acceptance. `nf_dq_out` carries the byte and `nf_dq_oe` is high from the first strobe cycle to the last hold cycle.
- R8: A read of the data port lowers `nf_re_n` for PW+1 cycles and samples `nf_dq_in` on the last strobe clock. It then completes the bus read with that byte.
- R9: A data-port access made while a strobe or hold interval is in progress sees `bus_ready`=0 until the engine is idle.
- R10: Status register (address 3) bit 0 reads 1 while `nf_rb_n` is low (busy) and 0 while it is high.
- R11: Writing 1 to bit 0 of the reset register (address 4) makes that bit read 1 for RST_CYCLES cycles. The control and timing registers return to their R1 values, and the bit then clears itself.
- R12: `nf_we_n` and `nf_re_n` are never low in the same cycle, and the write byte does not change while `nf_dq_oe` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access completes this cycle |
| nf_cle | output | 1 | Command-latch enable pin |
| nf_ale | output | 1 | Address-latch enable pin |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write-protect pin, low protects |
| nf_dq_out | output | 8 | Byte driven toward the device |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte from the device |
| nf_rb_n | input | 1 | Ready/busy, low = busy |
| ecc_mode | output | 2 | ECC mode field |
| bus_sep | output | 1 | Bus-separation flag |

## Verification
On every cycle, the assertions check four things:
- the two strobes never overlap, and each strobe lasts exactly the latched width plus one;
- the write byte stays stable while driven;
- a returned read byte always follows a read strobe;
- after a soft reset the registers come back at their defaults.

Only the bench's scenarios can show the rest:
- that each control bit reaches the right pin with the right polarity;
- which clock the read byte is taken on;
- how long the hold interval lasts;
- that accesses stall while the engine is busy;
- the full soft-reset sequence as software sees it.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int TIME_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIMING = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_RESET  = 3'd4;

    localparam int B_CLE = 0;
    localparam int B_ALE = 1;
    localparam int B_CS  = 2;
    localparam int B_PEN = 3;
    localparam int B_ECC = 4;
    localparam int B_SEP = 6;

    localparam logic [DATA_W-1:0] CTRL_MASK    = 8'h7F;
    localparam logic [DATA_W-1:0] CTRL_DEFAULT = 8'h00;
    localparam logic [DATA_W-1:0] TIME_DEFAULT = 8'hFF;

    typedef enum logic [1:0] {
        ECC_OFF   = 2'b00,
        ECC_RESET = 2'b01,
        ECC_ACCUM = 2'b10,
        ECC_READ  = 2'b11
    } ecc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_HOLD
    } strobe_state_e;
endpackage

// File: rtl/nbc_regs.sv
module nbc_regs
    import nbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] timing_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_DEFAULT;
            timing_q <= TIME_DEFAULT;
        end else if (soft_clr) begin
            ctrl_q   <= CTRL_DEFAULT;
            timing_q <= TIME_DEFAULT;
        end else if (wr_en) begin
            if (addr == A_CTRL)   ctrl_q   <= wdata & CTRL_MASK;
            if (addr == A_TIMING) timing_q <= wdata;
        end
    end

    AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_clr) |-> (ctrl_q == CTRL_DEFAULT && timing_q == TIME_DEFAULT)); // R11

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0); // R5
endmodule

// File: rtl/nbc_reset_seq.sv
module nbc_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (!active) begin
            if (trigger) begin
                active <= 1'b1;
                cnt_q  <= CW'(RST_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            active <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/nbc_strobe_fsm.sv
module nbc_strobe_fsm
    import nbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] pw,
    input  logic [TIME_W-1:0] hold,
    input  logic [DATA_W-1:0] dq_in,
    output logic              idle,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              sample_done,
    output logic [DATA_W-1:0] rd_data
);
    strobe_state_e     state_q, state_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic [TIME_W-1:0] hold_q, hold_d;
    logic [TIME_W-1:0] pw_q, pw_d;
    logic              is_rd_q, is_rd_d;
    logic [DATA_W-1:0] dout_q, dout_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hold_d  = hold_q;
        pw_d    = pw_q;
        is_rd_d = is_rd_q;
        dout_d  = dout_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_wr || start_rd) begin
                        state_d = ST_STROBE;
                        cnt_d   = pw;
                        pw_d    = pw;
                        hold_d  = hold;
                        is_rd_d = start_rd;
                        if (start_wr) dout_d = wdata;
                    end
                end
                ST_STROBE: begin
                    if (cnt_q == '0) begin
                        if (hold_q == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_HOLD;
                            cnt_d   = hold_q - 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == '0) state_d = ST_IDLE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            pw_q    <= '0;
            is_rd_q <= 1'b0;
            dout_q  <= '0;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hold_q  <= hold_d;
            pw_q    <= pw_d;
            is_rd_q <= is_rd_d;
            dout_q  <= dout_d;
            if (sample_done) rd_data <= dq_in;
        end
    end

    always_comb begin
        idle        = (state_q == ST_IDLE);
        we_n        = !(state_q == ST_STROBE && !is_rd_q);
        re_n        = !(state_q == ST_STROBE && is_rd_q);
        dq_oe       = (state_q != ST_IDLE) && !is_rd_q;
        dq_out      = dout_q;
        sample_done = (state_q == ST_STROBE) && is_rd_q && (cnt_q == '0) && !abort;
    end

    logic [TIME_W:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  len_q <= '0;
        else if (state_q == ST_STROBE) len_q <= len_q + 1'b1;
        else                         len_q <= '0;
    end

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && state_d != ST_STROBE && !abort)
            |-> (len_q == {1'b0, pw_q})); // R6

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R12
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic              nf_wp_n,
    output logic [DATA_W-1:0] nf_dq_out,
    output logic              nf_dq_oe,
    input  logic [DATA_W-1:0] nf_dq_in,
    input  logic              nf_rb_n,
    output logic [1:0]        ecc_mode,
    output logic              bus_sep
);
    logic [DATA_W-1:0] ctrl_q, timing_q, rd_buf;
    logic              rst_active, fsm_idle, sample_done;
    logic              rd_pend_q, rd_valid_q;
    logic              is_data, wr_accept, rd_issue, rd_ack, reg_wr, rst_trig;

    always_comb begin
        is_data   = bus_sel && (bus_addr == A_DATA);
        wr_accept = is_data && bus_wr && fsm_idle && !rst_active;
        rd_issue  = is_data && !bus_wr && fsm_idle && !rd_pend_q && !rd_valid_q && !rst_active;
        rd_ack    = is_data && !bus_wr && rd_valid_q;
        reg_wr    = bus_sel && bus_wr && !rst_active && (bus_addr != A_DATA);
        rst_trig  = reg_wr && (bus_addr == A_RESET) && bus_wdata[0];
        if (!is_data)    bus_ready = 1'b1;
        else if (bus_wr) bus_ready = fsm_idle && !rst_active;
        else             bus_ready = rd_valid_q;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_DATA:   bus_rdata = rd_buf;
            A_TIMING: bus_rdata = timing_q;
            A_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, !nf_rb_n};
            A_RESET:  bus_rdata = {{(DATA_W-1){1'b0}}, rst_active};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q  <= 1'b0;
            rd_valid_q <= 1'b0;
        end else if (rst_active) begin
            rd_pend_q  <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            if (rd_issue)         rd_pend_q <= 1'b1;
            else if (sample_done) rd_pend_q <= 1'b0;
            if (sample_done)      rd_valid_q <= 1'b1;
            else if (rd_ack)      rd_valid_q <= 1'b0;
        end
    end

    nbc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (rst_active),
        .wr_en    (reg_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .timing_q (timing_q)
    );

    nbc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (rst_trig),
        .active  (rst_active)
    );

    nbc_strobe_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (rst_active),
        .start_wr    (wr_accept),
        .start_rd    (rd_issue),
        .wdata       (bus_wdata),
        .pw          (timing_q[TIME_W-1:0]),
        .hold        (timing_q[2*TIME_W-1:TIME_W]),
        .dq_in       (nf_dq_in),
        .idle        (fsm_idle),
        .we_n        (nf_we_n),
        .re_n        (nf_re_n),
        .dq_out      (nf_dq_out),
        .dq_oe       (nf_dq_oe),
        .sample_done (sample_done),
        .rd_data     (rd_buf)
    );

    always_comb begin
        nf_cle   = ctrl_q[B_CLE];
        nf_ale   = ctrl_q[B_ALE];
        nf_ce_n  = !ctrl_q[B_CS];
        nf_wp_n  = ctrl_q[B_PEN];
        ecc_mode = ctrl_q[B_ECC+1:B_ECC];
        bus_sep  = ctrl_q[B_SEP];
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n)); // R12

    AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_q) |-> $past(!nf_re_n)); // R8

    AST_NO_STROBE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && $past(rst_active)) |-> (nf_we_n && nf_re_n)); // R11
endmodule

// File: tb/sim_nand_bus_ctrl.sv
module sim_nand_bus_ctrl;
    localparam int CLK_P = 10;
    localparam int RSTC  = 4;

    logic       clk = 0, rst_n = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       bus_ready;
    logic       nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_wp_n, nf_dq_oe, bus_sep;
    logic [7:0] nf_dq_out, nf_dq_in = 8'h00;
    logic       nf_rb_n = 1;
    logic [1:0] ecc_mode;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    nand_bus_ctrl #(.RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
        .nf_rb_n(nf_rb_n), .ecc_mode(ecc_mode), .bus_sep(bus_sep)
    );

    // {write value, expected readback, expected {0,cle,ale,ce_n,wp_n,ecc[1:0],sep}}
    localparam logic [23:0] CTRL_VEC [10] = '{
        24'h01_01_50, 24'h02_02_30, 24'h04_04_00, 24'h08_08_18, 24'h10_10_12,
        24'h20_20_14, 24'h30_30_16, 24'h40_40_11, 24'h0F_0F_68, 24'h80_00_10
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [2:0] a, input logic w, input logic [7:0] d,
                        output logic [7:0] r);
        bit fin = 0;
        @(negedge clk);
        bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
        while (!fin) begin
            #1;
            if (bus_ready) begin
                r = bus_rdata;
                fin = 1;
                @(negedge clk);
                bus_sel = 0; bus_wr = 0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [7:0] pins();
        return {1'b0, nf_cle, nf_ale, nf_ce_n, nf_wp_n, ecc_mode, bus_sep};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins", {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_wp_n, ecc_mode},
              {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00});
        xfer(3'd0, 0, 0, r); check("R1 ctrl", r, 8'h00);
        xfer(3'd2, 0, 0, r); check("R1 timing", r, 8'hFF);

        // R2 R3 R4 R5 control table
        foreach (CTRL_VEC[i]) begin
            xfer(3'd0, 1, CTRL_VEC[i][23:16], r);
            check("R2/R3/R4/R5 pins", pins(), CTRL_VEC[i][7:0]);
            xfer(3'd0, 0, 0, r);
            check("R5 readback", r, CTRL_VEC[i][15:8]);
        end

        // R6 R7 write strobe: PW=8, HOLD=2
        xfer(3'd2, 1, 8'h28, r);
        xfer(3'd1, 1, 8'h3C, r);
        cnt = 0;
        while (!nf_we_n) begin
            if (!(nf_dq_oe && nf_dq_out == 8'h3C)) check("R7 data during strobe", nf_dq_out, 8'h3C);
            cnt++; @(negedge clk);
        end
        check("R7 R6 strobe width", cnt, 9);
        cnt = 0;
        while (nf_dq_oe) begin cnt++; @(negedge clk); end
        check("R6 hold length", cnt, 2);

        // R9 stall: second write while first strobe runs (PW=3, HOLD=4)
        xfer(3'd2, 1, 8'h43, r);
        xfer(3'd1, 1, 8'h11, r);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 8'h22;
        #1;
        check("R9 stall in strobe", bus_ready, 0);
        repeat (4) @(negedge clk);
        #1;
        check("R9 stall in hold", bus_ready, 0);
        bus_sel = 0;
        xfer(3'd1, 1, 8'h22, r);
        check("R9 second write data", nf_dq_out, 8'h22);

        // R8 read: PW=5, HOLD=0, data valid only on last strobe clock
        xfer(3'd2, 1, 8'h05, r);
        while (nf_dq_oe) @(negedge clk);
        fork
            xfer(3'd1, 0, 0, r);
            begin
                int k = 0;
                while (nf_re_n) @(negedge clk);
                while (!nf_re_n) begin
                    k++;
                    nf_dq_in = (k == 6) ? 8'h5C : 8'hEE;
                    @(negedge clk);
                end
                check("R8 read strobe width", k, 6);
            end
        join
        check("R8 read data", r, 8'h5C);

        // R10 status
        nf_rb_n = 0;
        xfer(3'd3, 0, 0, r); check("R10 busy", r, 8'h01);
        nf_rb_n = 1;
        xfer(3'd3, 0, 0, r); check("R10 ready", r, 8'h00);

        // R11 soft reset
        xfer(3'd0, 1, 8'h7F, r);
        xfer(3'd2, 1, 8'h21, r);
        xfer(3'd4, 1, 8'h01, r);
        xfer(3'd4, 0, 0, r); check("R11 bit set", r, 8'h01);
        repeat (RSTC + 2) @(negedge clk);
        xfer(3'd4, 0, 0, r); check("R11 bit clear", r, 8'h00);
        xfer(3'd0, 0, 0, r); check("R11 ctrl default", r, 8'h00);
        xfer(3'd2, 0, 0, r); check("R11 timing default", r, 8'hFF);
        check("R11 ce_n", nf_ce_n, 1);

        finish_run();
    end
endmodule